// File: doc/BRIEF.md
# Octal DAC Command Register Bank

This block sits behind a serial receiver that has already gathered three bytes into one 24-bit command word. Each word, presented for one clock with a valid strobe, carries a 4-bit operation, a 4-bit channel select and a 16-bit data field. The block applies the word to eight converter channels. Each channel keeps a staging (input) code and an active code that drives its output. Loading a code and making it active are separate steps, so several channels can be staged and then switched together.

Each channel can be put to sleep. A sleeping channel keeps both of its codes, and any operation that makes a code active wakes it again. A shared bias enable turns off once every channel is asleep. After a wake, a per-channel busy flag models the settling delay. The delay is short when the bias was already running and long when the bias had to be restarted. Both delays are parameters counted in clock cycles.

Each channel is a three-state machine. `CH_ON` moves to `CH_OFF` on a sleep command. `CH_OFF` moves to `CH_WAKE` on an update and loads the delay counter. `CH_WAKE` returns to `CH_ON` when the counter reaches zero, or goes to `CH_OFF` on a new sleep command. The bias controller has two states. `BIAS_ON` moves to `BIAS_OFF` when a sleep command leaves all channels asleep and no update is in the same word. `BIAS_OFF` moves back to `BIAS_ON` on any update.

Top module: `dac_cmd_bank`

## Requirements
- R1: After reset all active codes read zero, no channel is asleep, the bias enable is high and no busy flag is set.
- R2: Word layout: operation in bits 23..20, channel select in bits 19..16, data in bits 15..0. Select values 0 to 7 pick one channel and 15 picks all eight. Any other select value makes the whole word have no effect.
- R3: Operation 0000 loads the data into the staging code of the selected channels and leaves every active code and sleep flag unchanged.
- R4: Operation 0001 copies the staging code of each selected channel into its active code and clears its sleep flag.
- R5: Operation 0011 loads the data into both the staging and active codes of the selected channels and clears their sleep flags.
- R6: Operation 0010 loads the data into the staging code of the selected channels, then copies the staging code into the active code of all eight channels and clears all sleep flags.
- R7: Operation 0100 sets the sleep flag of the selected channels, ignores the data and leaves all codes unchanged.
- R8: With resolution RES, the low 16-RES bits of the data are ignored and are stored and output as zero.
- R9: The bias enable goes low when a sleep command leaves all eight channels asleep. It goes high again with the next word that performs an update.
- R10: An update that wakes a sleeping channel raises its busy flag for SHORT_CYC cycles if the bias was high before the word, or for LONG_CYC cycles if it was low. Updating an awake channel does not raise busy. A sleep command on a busy channel clears busy and sets its sleep flag.
- R11: Operation 1111, the unlisted operation codes and cycles with the valid strobe low change no output except the countdown of busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Command word valid for this cycle |
| word | input | 24 | Operation, channel select and data |
| act_code | output | 16*NCH | Active codes, channel i in bits 16i+15..16i |
| pd_flags | output | NCH | Per-channel sleep flag |
| bias_en | output | 1 | Shared bias enable |
| busy | output | NCH | Per-channel wake settling flag |

## Verification
A wrong staging code stays hidden until a later update makes it active. The bench therefore stages values, issues single-channel and broadcast updates, and compares every active code on the clock edge after each word. A channel state machine stuck in the wrong state shows within one word as a sleep flag or busy flag that disagrees with the model. A delay counter loaded with the wrong length only shows when busy falls, so the short and long wake cases are checked on every cycle until the flag drops. A bias controller fault shows in the bias enable on the edge after the sleep word that turns the last channel off, and again in the wrong busy length on the next wake.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
    typedef enum logic [3:0] {
        OP_WRITE       = 4'b0000,
        OP_UPDATE      = 4'b0001,
        OP_WRITE_UPALL = 4'b0010,
        OP_WRITE_UPD   = 4'b0011,
        OP_SLEEP       = 4'b0100,
        OP_NOP         = 4'b1111
    } op_e;

    typedef enum logic [1:0] {
        CH_ON   = 2'd0,
        CH_OFF  = 2'd1,
        CH_WAKE = 2'd2
    } ch_state_e;

    typedef enum logic {
        BIAS_ON  = 1'b1,
        BIAS_OFF = 1'b0
    } bias_state_e;

    localparam logic [3:0] SEL_ALL = 4'hF;
    localparam int         DW      = 16;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_bank_pkg::*;
#(
    parameter int NCH = 8,
    parameter int RES = 16
) (
    input  logic            word_vld,
    input  logic [23:0]     word,
    output logic [NCH-1:0]  wr_mask,
    output logic [NCH-1:0]  upd_mask,
    output logic [NCH-1:0]  pd_mask,
    output logic [DW-1:0]   data
);
    localparam logic [DW-1:0] KEEP = {DW{1'b1}} << (DW - RES);

    logic [3:0]     op;
    logic [3:0]     sel_code;
    logic [NCH-1:0] sel;

    assign op       = word[23:20];
    assign sel_code = word[19:16];
    assign data     = word[15:0] & KEEP;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            sel[i] = (sel_code == SEL_ALL) || (int'(sel_code) == i);
        end
    end

    always_comb begin
        wr_mask  = '0;
        upd_mask = '0;
        pd_mask  = '0;
        if (word_vld) begin
            case (op)
                OP_WRITE:       wr_mask = sel;
                OP_UPDATE:      upd_mask = sel;
                OP_WRITE_UPALL: begin
                    wr_mask  = sel;
                    upd_mask = (|sel) ? {NCH{1'b1}} : '0;
                end
                OP_WRITE_UPD: begin
                    wr_mask  = sel;
                    upd_mask = sel;
                end
                OP_SLEEP:       pd_mask = sel;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_bank_pkg::*;
#(
    parameter int SHORT_CYC = 250,
    parameter int LONG_CYC  = 1500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          upd,
    input  logic          pd,
    input  logic [DW-1:0] din,
    input  logic          bias_on,
    output logic [DW-1:0] code,
    output logic          pd_flag,
    output logic          busy
);
    localparam int MAXD = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW   = $clog2(MAXD + 1);

    ch_state_e       state, nxt;
    logic [CW-1:0]   cnt;
    logic [DW-1:0]   stage;
    logic [DW-1:0]   stage_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_ON;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_ON:   if (pd) nxt = CH_OFF;
            CH_OFF:  if (upd) nxt = CH_WAKE;
            CH_WAKE: begin
                if (pd)             nxt = CH_OFF;
                else if (cnt == '0) nxt = CH_ON;
            end
            default: nxt = CH_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == CH_OFF && upd) begin
            cnt <= bias_on ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
        end else if (state == CH_WAKE && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign stage_nxt = wr ? din : stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
            code  <= '0;
        end else begin
            stage <= stage_nxt;
            if (upd) code <= stage_nxt;
        end
    end

    always_comb begin
        pd_flag = (state == CH_OFF);
        busy    = (state == CH_WAKE);
    end
endmodule

// File: rtl/dac_bias_ctl.sv
module dac_bias_ctl
    import dac_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_any,
    input  logic [NCH-1:0] pd_mask,
    input  logic [NCH-1:0] pd_now,
    output logic           bias_en
);
    bias_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BIAS_ON;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BIAS_ON:  if (!upd_any && (&(pd_now | pd_mask))) nxt = BIAS_OFF;
            BIAS_OFF: if (upd_any) nxt = BIAS_ON;
            default:  nxt = BIAS_ON;
        endcase
    end

    always_comb begin
        bias_en = (state == BIAS_ON);
    end
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
    import dac_bank_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int RES       = 16,
    parameter int SHORT_CYC = 250,
    parameter int LONG_CYC  = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [23:0]       word,
    output logic [DW*NCH-1:0] act_code,
    output logic [NCH-1:0]    pd_flags,
    output logic              bias_en,
    output logic [NCH-1:0]    busy
);
    logic [NCH-1:0] wr_mask, upd_mask, pd_mask;
    logic [DW-1:0]  data;

    dac_cmd_decode #(.NCH(NCH), .RES(RES)) u_dec (
        .word_vld (word_vld),
        .word     (word),
        .wr_mask  (wr_mask),
        .upd_mask (upd_mask),
        .pd_mask  (pd_mask),
        .data     (data)
    );

    dac_bias_ctl #(.NCH(NCH)) u_bias (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_any (|upd_mask),
        .pd_mask (pd_mask),
        .pd_now  (pd_flags),
        .bias_en (bias_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dac_chan #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_mask[g]),
            .upd     (upd_mask[g]),
            .pd      (pd_mask[g]),
            .din     (data),
            .bias_on (bias_en),
            .code    (act_code[g*DW +: DW]),
            .pd_flag (pd_flags[g]),
            .busy    (busy[g])
        );
    end
endmodule

// File: rtl/dac_cmd_bank_chk.sv
module dac_cmd_bank_chk #(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic [23:0]       word,
    input logic [16*NCH-1:0] act_code,
    input logic [NCH-1:0]    pd_flags,
    input logic              bias_en,
    input logic [NCH-1:0]    busy
);
    assert_bias_tracks_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en == !(&pd_flags));

    assert_sleep_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flags & busy) == '0);

    assert_busy_from_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy & ~$past(busy)) & ~$past(pd_flags)) == '0);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(act_code) && $stable(pd_flags)));

    assert_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word[23:20] == 4'b0000) |=> ($stable(act_code) && $stable(pd_flags)));
endmodule

bind dac_cmd_bank dac_cmd_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word     (word),
    .act_code (act_code),
    .pd_flags (pd_flags),
    .bias_en  (bias_en),
    .busy     (busy)
);

// File: tb/tb_dac_cmd_bank.sv
module tb_dac_cmd_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 8;
    localparam int RES   = 12;
    localparam int SHORT = 4;
    localparam int LONG  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_vld = 1'b0;
    logic [23:0]       word = '0;
    logic [16*NCH-1:0] act_code;
    logic [NCH-1:0]    pd_flags;
    logic              bias_en;
    logic [NCH-1:0]    busy;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_stage [NCH];
    logic [15:0] m_act   [NCH];
    logic        m_pd    [NCH];
    int          m_bcnt  [NCH];
    logic        m_bias;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_bank #(.NCH(NCH), .RES(RES), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .act_code(act_code), .pd_flags(pd_flags), .bias_en(bias_en), .busy(busy)
    );

    function automatic logic [15:0] trim(input logic [15:0] d);
        return d & (16'hFFFF << (16 - RES));
    endfunction

    function automatic logic [16*NCH-1:0] exp_codes();
        logic [16*NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*16 +: 16] = m_act[i];
        return v;
    endfunction

    function automatic logic [NCH-1:0] exp_pd();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = m_pd[i];
        return v;
    endfunction

    function automatic logic [NCH-1:0] exp_busy();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = (m_bcnt[i] > 0);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_stage[i] = '0; m_act[i] = '0; m_pd[i] = 1'b0; m_bcnt[i] = 0;
        end
        m_bias = 1'b1;
    endtask

    task automatic model_step(input logic vld, input logic [23:0] w);
        logic [3:0]  op = w[23:20];
        logic [3:0]  sc = w[19:16];
        logic [15:0] d  = trim(w[15:0]);
        logic        pre_bias = m_bias;
        bit          any_upd = 1'b0;
        bit          sel [NCH];
        bit          any_sel = 1'b0;
        bit          upd [NCH];
        bit          all_pd;
        for (int i = 0; i < NCH; i++) if (m_bcnt[i] > 0) m_bcnt[i]--;
        if (!vld) return;
        for (int i = 0; i < NCH; i++) begin
            sel[i] = (sc == 4'hF) || (int'(sc) == i);
            any_sel |= sel[i];
            upd[i] = 1'b0;
        end
        case (op)
            4'b0000: for (int i = 0; i < NCH; i++) if (sel[i]) m_stage[i] = d;
            4'b0001: for (int i = 0; i < NCH; i++) upd[i] = sel[i];
            4'b0010: if (any_sel) for (int i = 0; i < NCH; i++) begin
                         if (sel[i]) m_stage[i] = d;
                         upd[i] = 1'b1;
                     end
            4'b0011: for (int i = 0; i < NCH; i++) if (sel[i]) begin
                         m_stage[i] = d; upd[i] = 1'b1;
                     end
            4'b0100: for (int i = 0; i < NCH; i++) if (sel[i]) begin
                         m_pd[i] = 1'b1; m_bcnt[i] = 0;
                     end
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) if (upd[i]) begin
            any_upd = 1'b1;
            m_act[i] = m_stage[i];
            if (m_pd[i]) begin
                m_pd[i] = 1'b0;
                m_bcnt[i] = pre_bias ? SHORT : LONG;
            end
        end
        all_pd = 1'b1;
        for (int i = 0; i < NCH; i++) all_pd &= m_pd[i];
        if (any_upd)     m_bias = 1'b1;
        else if (all_pd) m_bias = 1'b0;
    endtask

    task automatic check(input string tag);
        n_vec++;
        if (act_code !== exp_codes() || pd_flags !== exp_pd() ||
            bias_en !== m_bias || busy !== exp_busy()) begin
            n_bad++;
            $display("FAIL %s: codes=%h pd=%b bias=%b busy=%b expected codes=%h pd=%b bias=%b busy=%b",
                     tag, act_code, pd_flags, bias_en, busy,
                     exp_codes(), exp_pd(), m_bias, exp_busy());
        end
    endtask

    task automatic apply(input logic vld, input logic [3:0] op, input logic [3:0] sc,
                         input logic [15:0] d, input string tag);
        word_vld = vld;
        word     = {op, sc, d};
        @(posedge clk);
        #1 model_step(vld, {op, sc, d});
        @(negedge clk);
        word_vld = 1'b0;
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) apply(1'b0, 4'h0, 4'h0, 16'h0, tag);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        apply(1, 4'b0000, 4'd2, 16'hABCD, "R3 write staging only");
        apply(1, 4'b0001, 4'd2, 16'h0000, "R4 update copies staging");
        apply(1, 4'b0011, 4'd5, 16'h1234, "R5 write and update; R8 low bits zero");
        apply(1, 4'b0000, 4'd0, 16'hFFFF, "R3 stage ch0");
        apply(1, 4'b0010, 4'd1, 16'h5555, "R6 write then update all");
        apply(1, 4'b0100, 4'd3, 16'h9999, "R7 sleep keeps codes");
        apply(1, 4'b0011, 4'd9, 16'h7777, "R2 invalid select ignored");
        apply(1, 4'b1111, 4'd4, 16'h7777, "R11 nop");
        apply(1, 4'b0111, 4'd4, 16'h7777, "R11 unlisted op");
        apply(1, 4'b0001, 4'd3, 16'h0000, "R10 short wake");
        idle(SHORT + 1, "R10 short busy window");
        apply(1, 4'b0001, 4'd4, 16'h0000, "R10 awake update no busy");
        apply(1, 4'b0100, 4'hF, 16'h0000, "R9 all asleep bias off");
        apply(1, 4'b0001, 4'd1, 16'h0000, "R9 update restores bias; R10 long wake");
        idle(LONG + 1, "R10 long busy window");
        apply(1, 4'b0011, 4'd6, 16'h0F0F, "R2 select one");
        apply(1, 4'b0100, 4'd6, 16'h0000, "R7 sleep ch6");
        apply(1, 4'b0001, 4'd6, 16'h0000, "R10 wake ch6");
        apply(1, 4'b0100, 4'd6, 16'h0000, "R10 sleep during busy");
        apply(1, 4'b0010, 4'hF, 16'hC3C3, "R6 broadcast write update all");
        idle(SHORT + 1, "R10 settle");

        for (int k = 0; k < 4000; k++) begin
            logic [3:0] op, sc;
            int r = $urandom_range(0, 9);
            case (r)
                0, 1: op = 4'b0000;
                2:    op = 4'b0001;
                3:    op = 4'b0010;
                4:    op = 4'b0011;
                5, 6: op = 4'b0100;
                7:    op = 4'b1111;
                default: op = 4'($urandom_range(0, 15));
            endcase
            r = $urandom_range(0, 11);
            sc = (r < 8) ? 4'(r) : (r < 10) ? 4'hF : 4'($urandom_range(8, 14));
            apply(1'($urandom_range(0, 3) != 0), op, sc, 16'($urandom()),
                  "R2 R11 random mix");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule